// File: doc/BRIEF.md
# Odd-Multiple Product Table with Shift Recovery

This block turns a 4-bit coded operand into the coded product word that a later offset add/subtract stage needs when it multiplies by a fixed coefficient. The coefficient is fixed when the design is elaborated. The table is computed from it, and it holds only nine words. Eight of them are the odd multiples of the coefficient. The ninth is twice the coefficient.

A nonzero operand has its trailing zeros stripped off. The odd value that remains picks a table word. A two-stage logarithmic left shifter then moves that word back up by the number of zeros that were stripped, which is between 0 and 3. An all-zero operand picks the spare word and shifts it by three places, which gives sixteen times the coefficient.

The side bit `hi_i` has one job. When it is high and the operand is all zero, the output is forced to zero. The path is purely combinational: the word follows the inputs in the same cycle, with no handshake and no register. Because nothing is stored, no back-pressure rule applies.

Top module: `oddlut_coder`

## Requirements
- R1: For a nonzero `code_i`, `word_o` equals COEF times `code_i`, zero-extended to 16 bits. This holds for either value of `hi_i`.
- R2: For `code_i` = 0 with `hi_i` = 0, `word_o` equals 16 times COEF.
- R3: For `code_i` = 0 with `hi_i` = 1, `word_o` is zero.
- R4: For any nonzero `code_i`, `hi_i` has no effect on `word_o`.
- R5: Bits 15 and 14 of `word_o` are always zero, for every coefficient that fits in 10 bits.
- R6: `word_o` settles to the new value in the same cycle that the inputs change, with no clock latency.
- R7: Exactly one of the nine internal word-select lines is active for every value of `code_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_i | input | 4 | Coded operand |
| hi_i | input | 1 | Side bit; when high together with an all-zero operand, the output is cleared |
| word_o | output | 16 | Coded product word, unsigned |

## Verification
Two functions can fall in the same cycle: the largest shift, three places applied to the spare 2A word, and the forced clear. Both are triggered by the same all-zero operand. The bench provokes them together by driving `code_i` = 0 with `hi_i` high, and then again with `hi_i` low. It expects zero for the first case and 16 times the coefficient for the second. This sweep runs across four coefficients, including 1023 and 1, so that a clear that leaks, or a shift that drops a stage, shows up as a wrong value.

// File: rtl/oddlut_pkg.sv
package oddlut_pkg;
  localparam int unsigned COEF_W_DEF = 10;
  localparam int unsigned CODE_W_DEF = 4;
  localparam int unsigned WORD_W_DEF = 16;

  // number of stored words: odd multiples plus one spare
  function automatic int unsigned entries(input int unsigned code_w);
    return (1 << (code_w - 1)) + 1;
  endfunction
endpackage

// File: rtl/oddlut_addr_map.sv
module oddlut_addr_map #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned SH_W = $clog2(CODE_W)
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] addr,
  output logic [SH_W-1:0]   shamt
);
  int unsigned low;

  always_comb begin
    low = 0;
    for (int k = CODE_W - 1; k >= 0; k--) begin
      if (code[k]) low = k;
    end
    if (code == '0) begin
      addr  = CODE_W'(1 << (CODE_W - 1));
      shamt = SH_W'(CODE_W - 1);
    end else begin
      addr  = (code >> low) >> 1;
      shamt = SH_W'(low);
    end
  end

  // R1: odd index and shift rebuild the operand
  always_comb begin
    if (!$isunknown(code) && code != '0)
      a_r1_addr_rebuilds: assert ((({addr[CODE_W-2:0], 1'b1}) << shamt) == {1'b0, code});
  end
endmodule

// File: rtl/oddlut_decoder.sv
module oddlut_decoder #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  sel
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign sel[i] = (addr == ADDR_W'(i));
  end

  // R7: one word select line per operand
  always_comb begin
    if (!$isunknown(addr))
      a_r7_sel_onehot: assert ($onehot(sel));
  end
endmodule

// File: rtl/oddlut_table.sv
module oddlut_table #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 9,
  parameter int unsigned COEF   = 1
) (
  input  logic [DEPTH-1:0]  sel,
  output logic [WORD_W-1:0] rd
);
  logic [WORD_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i < DEPTH - 1) begin : g_odd
      assign words[i] = WORD_W'(COEF * (2 * i + 1));
    end else begin : g_spare
      assign words[i] = WORD_W'(COEF * 2);
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < DEPTH; i++) rd = rd | (words[i] & {WORD_W{sel[i]}});
  end
endmodule

// File: rtl/oddlut_shifter.sv
module oddlut_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SH_W   = 2
) (
  input  logic [WORD_W-1:0] din,
  input  logic [SH_W-1:0]   shamt,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] stage [SH_W+1];

  assign stage[0] = din;
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stage[s+1] = shamt[s] ? (stage[s] << (1 << s)) : stage[s];
  end
  assign dout = stage[SH_W];
endmodule

// File: rtl/oddlut_coder.sv
module oddlut_coder
  import oddlut_pkg::*;
#(
  parameter int unsigned COEF_W = COEF_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned COEF   = 677,
  localparam int unsigned SH_W  = $clog2(CODE_W),
  localparam int unsigned DEPTH = entries(CODE_W)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              hi_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CODE_W-1:0] addr;
  logic [SH_W-1:0]   shamt;
  logic [DEPTH-1:0]  sel;
  logic [WORD_W-1:0] rd;
  logic [WORD_W-1:0] shifted;
  logic              clear;

  oddlut_addr_map #(.CODE_W(CODE_W)) u_map (
    .code(code_i), .addr(addr), .shamt(shamt)
  );

  oddlut_decoder #(.ADDR_W(CODE_W), .DEPTH(DEPTH)) u_dec (
    .addr(addr), .sel(sel)
  );

  oddlut_table #(.WORD_W(WORD_W), .DEPTH(DEPTH), .COEF(COEF)) u_tab (
    .sel(sel), .rd(rd)
  );

  oddlut_shifter #(.WORD_W(WORD_W), .SH_W(SH_W)) u_sh (
    .din(rd), .shamt(shamt), .dout(shifted)
  );

  // spare-word address carries the top address bit
  assign clear  = addr[CODE_W-1] & hi_i;
  assign word_o = clear ? '0 : shifted;

  always_comb begin
    if (!$isunknown({code_i, hi_i})) begin
      // R3: zero operand with side bit high gives zero
      if (code_i == '0 && hi_i)
        a_r3_clear_zero: assert (word_o == '0);
      // R2: zero operand with side bit low gives 2^CODE_W times the coefficient
      if (code_i == '0 && !hi_i)
        a_r2_top_multiple: assert (word_o == WORD_W'(COEF << CODE_W));
      // R1: nonzero operand gives the exact product
      if (code_i != '0)
        a_r1_exact_product: assert (word_o == WORD_W'(COEF * code_i));
      // R5: product never reaches the top bits
      a_r5_upper_clear: assert ((word_o >> (COEF_W + CODE_W)) == '0);
    end
  end
endmodule

// File: tb/tb_oddlut_coder.sv
module tb_oddlut_coder;
  localparam int PERIOD = 10;
  localparam int NCOEF = 4;
  localparam int unsigned C0 = 1023;
  localparam int unsigned C1 = 677;
  localparam int unsigned C2 = 1;
  localparam int unsigned C3 = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] code = '0;
  logic hi = 1'b0;
  logic [15:0] w [NCOEF];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp [NCOEF];
    string tag;
    logic [3:0] code;
    logic hi;
  } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  oddlut_coder #(.COEF(C0)) dut   (.code_i(code), .hi_i(hi), .word_o(w[0]));
  oddlut_coder #(.COEF(C1)) dut_b (.code_i(code), .hi_i(hi), .word_o(w[1]));
  oddlut_coder #(.COEF(C2)) dut_c (.code_i(code), .hi_i(hi), .word_o(w[2]));
  oddlut_coder #(.COEF(C3)) dut_d (.code_i(code), .hi_i(hi), .word_o(w[3]));

  function automatic int unsigned coef_of(input int k);
    case (k)
      0: return C0;
      1: return C1;
      2: return C2;
      default: return C3;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic h);
    item_t it;
    @(posedge clk);
    #1;
    code = c;
    hi = h;
    for (int k = 0; k < NCOEF; k++) begin
      if (c != 0) it.exp[k] = 16'(coef_of(k) * c);
      else if (h) it.exp[k] = 16'd0;
      else it.exp[k] = 16'(coef_of(k) * 16);
    end
    if (c != 0) it.tag = h ? "R4" : "R1";
    else it.tag = h ? "R3" : "R2";
    it.code = c;
    it.hi = h;
    q.push_back(it);
  endtask

  // monitor: compares half a period after each drive
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      for (int k = 0; k < NCOEF; k++) begin
        check(it.tag, w[k], it.exp[k]);
        check("R5", {14'd0, w[k][15:14]}, 16'd0);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // idle state after reset: zero operand, side bit low gives 16 times coefficient (R2)
    check("R2", w[0], 16'(C0 * 16));
    rst = 1'b0;
    // full sweep of both side-bit values (R1 R2 R3 R4)
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 16; c++) send(4'(c), h[0]);
    // clear and largest shift back to back on the zero operand (R2 R3)
    send(4'd0, 1'b1);
    send(4'd0, 1'b0);
    send(4'd8, 1'b1);
    send(4'd0, 1'b1);
    // same-cycle response without any clock edge (R6)
    @(posedge clk);
    #2;
    code = 4'd12;
    hi = 1'b1;
    #1;
    check("R6", w[1], 16'(C1 * 12));
    code = 4'd0;
    #1;
    check("R6", w[1], 16'd0);
    hi = 1'b0;
    #1;
    check("R6", w[2], 16'(C2 * 16));
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule